// File: doc/BRIEF.md
# ATM Cell Transmit Processor

This block is the transmit half of one cell-based transmission convergence port. An upstream agent writes whole 53-byte cells, one byte per cycle, into a local store that holds four cells. The block then sends them to an external framer. Each outgoing cell has its four header bytes either passed through or replaced by a programmed header word. The fifth byte is replaced by a freshly computed header check byte, and the 48 payload bytes are scrambled. The framer paces the stream with an enable input, and the stream leaves either a byte at a time or a bit at a time.

At every cell boundary the block checks for a complete stored cell. If none is waiting, it sends an idle cell so that the line never runs dry. The scrambler runs in one of two modes. The first is self-synchronising, where each bit is mixed with the line bit sent 43 bit times earlier. The second is distributed-sample, where a free-running 31-stage sequence is added to the payload. A counter tracks user cells sent and hands over its value on a once-per-second strobe.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: Byte 5 of every outgoing cell (user or idle) equals CRC-8 with generator x^8+x^2+x+1, computed over header bytes 1 to 4 as sent (MSB first, initial value 0x00), XORed with 0x55. The fifth byte written into the store is discarded.
- R2: When `cfg_hdr_ins` is 1, header bytes 1 to 4 of a user cell are `cfg_hdr[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` in that order. When it is 0, they are the stored bytes 1 to 4.
- R3: If no complete cell is stored when byte 1 of a cell is due, an idle cell goes out. Its header is 0x00 0x00 0x00 0x01 and each payload byte is 0x6A before scrambling. The choice is made only at byte 1.
- R4: With `cfg_dss` = 0, every payload bit d becomes o = d XOR (the payload bit sent 43 payload bits earlier). Bits are taken MSB first. The history is all zeros after reset. Header and check byte are never scrambled.
- R5: With `cfg_dss` = 1, every payload bit is XORed with k = s[30] of a 31-bit register s, and s then shifts to {s[29:0], s[30]^s[27]}. s is all ones after reset and steps once per payload bit of every cell, idle cells included. Header and check byte are never scrambled.
- R6: The store holds 4 complete cells, which are sent in the order written. `wr_full` is 1 while 4 cells are held. Bytes offered while `wr_full` is 1 are ignored.
- R7: In byte mode (`cfg_bit_mode` = 0), each cycle with `fr_en` = 1 puts the next byte on `tx_byte` at that clock edge, and `tx_soc` is 1 with byte 1 of a cell. In a cycle with `fr_en` = 0, no output changes.
- R8: In bit mode, each cycle with `fr_en` = 1 puts the next bit on `tx_bit`, MSB of each byte first. `tx_soc` is 1 only with the first bit of a cell.
- R9: Each user cell is counted when its last byte leaves. A `sec_strobe` pulse copies the running count to `tx_cells_sec` and restarts the count. A cell that ends in the strobe cycle counts toward the next interval.
- R10: After reset, `tx_byte`, `tx_bit`, `tx_soc`, `wr_full` and `tx_cells_sec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store one cell byte this cycle |
| wr_data | input | 8 | Cell byte, 53 per cell, first byte first |
| wr_full | output | 1 | Store holds four cells |
| cfg_hdr_ins | input | 1 | Replace user header with `cfg_hdr` |
| cfg_hdr | input | 32 | Programmed header, first byte in bits 31:24 |
| cfg_dss | input | 1 | 1 selects distributed-sample scrambling |
| cfg_bit_mode | input | 1 | 1 selects serial output |
| fr_en | input | 1 | Framer enable, advances the stream |
| sec_strobe | input | 1 | Once-per-second latch pulse |
| tx_byte | output | 8 | Byte-mode output |
| tx_bit | output | 1 | Bit-mode output |
| tx_soc | output | 1 | Marks the first byte or bit of a cell |
| tx_cells_sec | output | 16 | User cells sent in the last full interval |

## Verification
The assertions assume three things about the inputs. The configuration inputs stay still while cells are flowing. The writer offers whole 53-byte cells. `sec_strobe` is a single-cycle pulse. The bench keeps to these rules. It changes configuration only under reset, writes cells only as complete 53-byte bursts, and pulses the strobe for exactly one cycle. It then recovers the payload with its own descrambler model, which is independent of the design and restarts from the reset state in every scenario.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int HEC_POS    = 4;
  localparam logic [7:0]  HEC_POLY  = 8'h07;
  localparam logic [7:0]  HEC_COSET = 8'h55;
  localparam logic [31:0] IDLE_HDR  = 32'h0000_0001;
  localparam logic [7:0]  IDLE_FILL = 8'h6A;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ HEC_POLY) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] sel);
    case (sel)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction
endpackage

// File: rtl/atm_tx_fifo.sv
module atm_tx_fifo #(
  parameter int CELLS    = 4,
  parameter int IDX_W    = 6,
  parameter int LAST_IDX = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             wr_full,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             rd_avail,
  input  logic             rd_release
);
  localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int OCC_W  = $clog2(CELLS + 1);
  localparam int DEPTH  = (2 ** SLOT_W) << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LAST_IDX);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(CELLS);

  logic [7:0]       mem [DEPTH];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  wr_idx;
  logic [OCC_W-1:0]  occ;
  logic accept, wr_done;

  function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(CELLS - 1)) ? '0 : s + 1'b1;
  endfunction

  assign wr_full  = (occ == FULL);
  assign rd_avail = (occ != '0);
  assign accept   = wr_en && !wr_full;
  assign wr_done  = accept && (wr_idx == LAST);
  assign rd_data  = mem[{rd_slot, rd_idx}];

  always_ff @(posedge clk) begin
    if (accept) mem[{wr_slot, wr_idx}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot <= '0;
      rd_slot <= '0;
      wr_idx  <= '0;
      occ     <= '0;
    end else begin
      if (accept) wr_idx <= wr_done ? '0 : wr_idx + 1'b1;
      if (wr_done) wr_slot <= slot_next(wr_slot);
      if (rd_release) rd_slot <= slot_next(rd_slot);
      case ({wr_done, rd_release})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst) occ <= FULL);
  // R6
  full_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_full && wr_en) |=> $stable(wr_idx));
  // R6
  release_valid_chk: assert property (@(posedge clk) disable iff (rst) rd_release |-> rd_avail);
endmodule

// File: rtl/atm_tx_scrambler.sv
module atm_tx_scrambler #(
  parameter int SSC_LEN = 43,
  parameter int DSS_LEN = 31,
  parameter int DSS_TAP = 28
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       dss_sel,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [SSC_LEN-1:0] ssc_hist, ssc_nxt;
  logic [DSS_LEN-1:0] dss_st, dss_nxt;
  logic [7:0] ssc_out, dss_out;

  always_comb begin
    logic [SSC_LEN-1:0] h;
    logic [DSS_LEN-1:0] s;
    h = ssc_hist;
    s = dss_st;
    for (int i = 7; i >= 0; i--) begin
      ssc_out[i] = din[i] ^ h[SSC_LEN-1];
      h          = {h[SSC_LEN-2:0], ssc_out[i]};
      dss_out[i] = din[i] ^ s[DSS_LEN-1];
      s          = {s[DSS_LEN-2:0], s[DSS_LEN-1] ^ s[DSS_TAP-1]};
    end
    ssc_nxt = h;
    dss_nxt = s;
  end

  assign dout = dss_sel ? dss_out : ssc_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      ssc_hist <= '0;
      dss_st   <= '1;
    end else if (step) begin
      ssc_hist <= ssc_nxt;
      dss_st   <= dss_nxt;
    end
  end

  // R5
  dss_nonzero_chk: assert property (@(posedge clk) disable iff (rst) dss_st != '0);
endmodule

// File: rtl/atm_tx_cell_cnt.sv
module atm_tx_cell_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             sec_strobe,
  output logic [CNT_W-1:0] latched
);
  logic [CNT_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      latched <= '0;
    end else if (sec_strobe) begin
      latched <= run;
      run     <= inc ? CNT_W'(1) : '0;
    end else if (inc) begin
      run <= run + 1'b1;
    end
  end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    sec_strobe |=> run <= CNT_W'(1));
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc #(
  parameter int FIFO_CELLS = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             wr_full,
  input  logic             cfg_hdr_ins,
  input  logic [31:0]      cfg_hdr,
  input  logic             cfg_dss,
  input  logic             cfg_bit_mode,
  input  logic             fr_en,
  input  logic             sec_strobe,
  output logic [7:0]       tx_byte,
  output logic             tx_bit,
  output logic             tx_soc,
  output logic [CNT_W-1:0] tx_cells_sec
);
  import atm_tx_pkg::*;

  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_HEC  = IDX_W'(HEC_POS);
  localparam logic [IDX_W-1:0] IDX_PAY  = IDX_W'(HDR_BYTES + 1);

  logic [IDX_W-1:0] idx;
  logic [2:0] bit_cnt;
  logic       cur_user;
  logic [7:0] crc, sreg;

  logic       fetch, at_start, use_user, is_hdr, is_hec, is_pay, release_cell;
  logic       fifo_avail;
  logic [7:0] fifo_data, hdr_src, pay_plain, pay_scr, crc_in, cur_byte;

  assign fetch    = fr_en && (!cfg_bit_mode || bit_cnt == 3'd0);
  assign at_start = (idx == '0);
  assign use_user = at_start ? fifo_avail : cur_user;
  assign is_hdr   = (idx < IDX_HEC);
  assign is_hec   = (idx == IDX_HEC);
  assign is_pay   = (idx >= IDX_PAY);
  assign release_cell = fetch && (idx == IDX_LAST) && cur_user;

  always_comb begin
    if (!use_user)       hdr_src = word_byte(IDLE_HDR, idx[1:0]);
    else if (cfg_hdr_ins) hdr_src = word_byte(cfg_hdr, idx[1:0]);
    else                 hdr_src = fifo_data;
  end

  assign pay_plain = use_user ? fifo_data : IDLE_FILL;
  assign crc_in    = at_start ? 8'h00 : crc;

  always_comb begin
    if (is_hdr)      cur_byte = hdr_src;
    else if (is_hec) cur_byte = crc ^ HEC_COSET;
    else             cur_byte = pay_scr;
  end

  atm_tx_fifo #(.CELLS(FIFO_CELLS), .IDX_W(IDX_W), .LAST_IDX(CELL_BYTES - 1)) fifo_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_idx(idx), .rd_data(fifo_data), .rd_avail(fifo_avail), .rd_release(release_cell)
  );

  atm_tx_scrambler scr_i (
    .clk(clk), .rst(rst), .step(fetch && is_pay), .dss_sel(cfg_dss),
    .din(pay_plain), .dout(pay_scr)
  );

  atm_tx_cell_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .inc(release_cell), .sec_strobe(sec_strobe), .latched(tx_cells_sec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      bit_cnt  <= '0;
      cur_user <= 1'b0;
      crc      <= '0;
      sreg     <= '0;
      tx_byte  <= '0;
      tx_bit   <= 1'b0;
      tx_soc   <= 1'b0;
    end else begin
      if (!cfg_bit_mode)  bit_cnt <= '0;
      else if (fr_en)     bit_cnt <= bit_cnt + 1'b1;
      if (fetch) begin
        tx_byte  <= cur_byte;
        tx_bit   <= cur_byte[7];
        sreg     <= {cur_byte[6:0], 1'b0};
        tx_soc   <= at_start;
        cur_user <= use_user;
        idx      <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
        if (is_hdr) crc <= crc8_step(crc_in, hdr_src);
      end else if (fr_en) begin
        tx_bit <= sreg[7];
        sreg   <= {sreg[6:0], 1'b0};
        tx_soc <= 1'b0;
      end
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fr_en |=> ($stable(tx_byte) && $stable(tx_bit) && $stable(tx_soc)));
  // R3
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch && at_start && !fifo_avail) |=> (tx_byte == 8'h00 && tx_soc));
  // R8
  soc_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_bit_mode && fr_en && bit_cnt != 3'd0) |=> !tx_soc);
endmodule

// File: tb/atm_tx_cell_proc_tb.sv
module atm_tx_cell_proc_tb_top;
  typedef struct packed {
    logic        bitm;
    logic        dss;
    logic        ins;
    logic [1:0]  gap;
    logic [2:0]  ncells;
    logic        extra;
    logic [31:0] hdr;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    vec_t'({1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 1'b0, 32'h1234_5670, 8'h10}),
    vec_t'({1'b0, 1'b1, 1'b1, 2'd1, 3'd2, 1'b0, 32'h0A0B_0C00, 8'h80}),
    vec_t'({1'b1, 1'b0, 1'b0, 2'd0, 3'd1, 1'b0, 32'h0010_0020, 8'h33}),
    vec_t'({1'b1, 1'b1, 1'b1, 2'd2, 3'd1, 1'b0, 32'h7FF0_F0F0, 8'hC0}),
    vec_t'({1'b0, 1'b0, 1'b0, 2'd0, 3'd4, 1'b1, 32'h0102_0300, 8'h01}),
    vec_t'({1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 32'h0000_0000, 8'h00})
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, cfg_hdr_ins = 1'b0, cfg_dss = 1'b0, cfg_bit_mode = 1'b0;
  logic fr_en = 1'b0, sec_strobe = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [31:0] cfg_hdr = 32'h0;
  logic        wr_full, tx_bit, tx_soc;
  logic [7:0]  tx_byte;
  logic [15:0] tx_cells_sec;

  atm_tx_cell_proc dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .cfg_hdr_ins(cfg_hdr_ins), .cfg_hdr(cfg_hdr), .cfg_dss(cfg_dss),
    .cfg_bit_mode(cfg_bit_mode), .fr_en(fr_en), .sec_strobe(sec_strobe),
    .tx_byte(tx_byte), .tx_bit(tx_bit), .tx_soc(tx_soc), .tx_cells_sec(tx_cells_sec)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  vec_t cur;
  bit   en_run = 1'b0;
  int   gcnt = 0, rx_i = -1, bcnt = 0, user_seen = 0, idle_seen = 0;
  logic [7:0]  rx [53];
  logic [7:0]  bbuf;
  logic [42:0] m_h;
  logic [30:0] m_s;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hec_of(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = c[7] ^ h[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c ^ 8'h55;
  endfunction

  task automatic check_cell();
    logic [31:0] hdr = {rx[0], rx[1], rx[2], rx[3]};
    logic [7:0]  plain [48];
    logic [31:0] exp_h;
    logic [7:0]  exp_b, bad_a, bad_e;
    int nbad = 0;
    chk(rx[4] == hec_of(hdr), "R1 check byte", {24'h0, rx[4]}, {24'h0, hec_of(hdr)});
    for (int j = 0; j < 48; j++) begin
      for (int i = 7; i >= 0; i--) begin
        logic o = rx[j+5][i];
        if (cur.dss) begin
          plain[j][i] = o ^ m_s[30];
          m_s = {m_s[29:0], m_s[30] ^ m_s[27]};
        end else begin
          plain[j][i] = o ^ m_h[42];
          m_h = {m_h[41:0], o};
        end
      end
    end
    if (hdr == 32'h0000_0001) begin
      for (int j = 0; j < 48; j++) if (plain[j] != 8'h6A) begin nbad++; bad_a = plain[j]; end
      chk(nbad == 0, cur.dss ? "R3 R5 idle payload" : "R3 R4 idle payload", {24'h0, bad_a}, 32'h6A);
      chk(user_seen == int'(cur.ncells), "R3 idle only when store empty", user_seen, cur.ncells);
      idle_seen++;
    end else begin
      exp_h = cur.ins ? (cur.hdr ^ 32'h5A5A_5A00) : cur.hdr + 32'(user_seen);
      chk(hdr == exp_h, "R2 header", hdr, exp_h);
      for (int j = 0; j < 48; j++) begin
        exp_b = cur.seed + 8'(user_seen * 16) + 8'(j);
        if (plain[j] != exp_b) begin nbad++; bad_a = plain[j]; bad_e = exp_b; end
      end
      chk(nbad == 0, cur.dss ? "R5 R6 user payload" : "R4 R6 user payload", {24'h0, bad_a}, {24'h0, bad_e});
      user_seen++;
    end
  endtask

  // Monitor and framer-enable driver, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (en_run && fr_en) begin
      if (tx_soc) begin rx_i = 0; bcnt = 0; end
      if (rx_i >= 0) begin
        if (cur.bitm) begin
          bbuf = {bbuf[6:0], tx_bit};
          bcnt++;
          if (bcnt == 8) begin rx[rx_i] = bbuf; rx_i++; bcnt = 0; end
        end else begin
          rx[rx_i] = tx_byte;
          rx_i++;
        end
        if (rx_i == 53) begin check_cell(); rx_i = -1; end
      end
    end
    if (en_run) begin
      fr_en = (gcnt == 0);
      gcnt  = (gcnt == int'(cur.gap)) ? 0 : gcnt + 1;
    end else begin
      fr_en = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic write_cell(input logic [31:0] h, input logic [7:0] s);
    for (int j = 0; j < 53; j++) begin
      @(negedge clk);
      wr_en = 1'b1;
      if (j < 4)       wr_data = 8'(h >> (8 * (3 - j)));
      else if (j == 4) wr_data = 8'hFF;
      else             wr_data = s + 8'(j - 5);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    for (int v = 0; v < NV; v++) begin
      int wait_n;
      logic [7:0] held;
      cur = VEC[v];
      en_run = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      cfg_bit_mode = cur.bitm;
      cfg_dss      = cur.dss;
      cfg_hdr_ins  = cur.ins;
      cfg_hdr      = cur.hdr ^ 32'h5A5A_5A00;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_h = '0; m_s = '1; user_seen = 0; idle_seen = 0; rx_i = -1; gcnt = 0;
      @(negedge clk);
      chk(tx_byte == 8'h00 && !tx_bit && !tx_soc && !wr_full, "R10 reset outputs",
          {tx_byte, 5'h0, tx_bit, tx_soc, wr_full}, 32'h0);
      chk(tx_cells_sec == 16'h0, "R10 reset count", tx_cells_sec, 0);
      for (int k = 0; k < int'(cur.ncells); k++)
        write_cell(cur.hdr + 32'(k), cur.seed + 8'(k * 16));
      @(negedge clk);
      chk(wr_full == (cur.ncells == 3'd4), "R6 full flag", wr_full, cur.ncells == 3'd4);
      if (cur.extra) begin
        write_cell(32'h3333_3333, 8'hEE);
        @(negedge clk);
        chk(wr_full == 1'b1, "R6 full after ignored write", wr_full, 1);
      end
      en_run = 1'b1;
      wait_n = 0;
      while (!(user_seen == int'(cur.ncells) && idle_seen >= 2) && wait_n < 20000) begin
        @(negedge clk);
        wait_n++;
      end
      en_run = 1'b0;
      chk(wait_n < 20000, "R7 stream progress", wait_n, 20000);
      chk(user_seen == int'(cur.ncells), "R6 user cells sent", user_seen, cur.ncells);
      @(negedge clk);
      held = tx_byte;
      repeat (5) @(negedge clk);
      chk(tx_byte == held, cur.bitm ? "R8 R7 hold without enable" : "R7 hold without enable",
          {24'h0, tx_byte}, {24'h0, held});
      chk(wr_full == 1'b0, "R6 store drained", wr_full, 0);
      sec_strobe = 1'b1;
      @(negedge clk);
      sec_strobe = 1'b0;
      chk(tx_cells_sec == 16'(cur.ncells), "R9 latched count", tx_cells_sec, cur.ncells);
      sec_strobe = 1'b1;
      @(negedge clk);
      sec_strobe = 1'b0;
      chk(tx_cells_sec == 16'h0, "R9 count restarted", tx_cells_sec, 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule